// File: doc/BRIEF.md
# Indirect-address MDIO management master

This block is the serial management master that reaches PHY registers through the two-step indirect scheme: the first frame loads a 16-bit register pointer into a chosen device of a chosen port, and the second frame reads or writes through that pointer. The host fills a command register with the pointer value, the device number, the port number, a two-bit opcode and a go bit. Setting go starts one frame on MDC/MDIO. Go reads back as 1 for as long as the frame runs and clears by itself at the end, so software polls it. Each access takes two commands with the same port and device fields: an address cycle, then a read or a write.

Write data is loaded into the low half of the data register before the write command is issued. A read returns its 16 bits in the upper half of the data register, and that half changes on the same clock edge on which go clears. MDC is the system clock divided by an even parameter `CLK_DIV`. MDIO changes on the falling edge of MDC, half an MDC period before the rising edge on which the PHY samples it. During a read the master releases the line from the turnaround onward and samples it on each rising edge of MDC.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the command word reads 0, the data word reads 0, MDC is low and the MDIO output enable is low.
- R2: Command word layout: bits 15:0 hold the register pointer, 20:16 the device, 25:21 the port, 27:26 the opcode, and bit 30 is go. Other bits read 0. Go reads 1 for exactly 64*CLK_DIV clocks and then clears. After a frame, the fields read back as they were written.
- R3: During a frame MDC has a period of CLK_DIV clocks. MDC is low for the first half of each bit and high for the second half, for 64 rising edges. Outside a frame MDC stays low.
- R4: Every frame begins with 32 one bits, followed by the start pattern 0,0.
- R5: After the start pattern the frame carries the opcode (2 bits), then the port (5 bits), then the device (5 bits), each most significant bit first. Opcode 00 is an address cycle, 01 a write, 11 a read, and 10 a read with pointer increment.
- R6: An address cycle drives the turnaround as 1,0 and then the 16-bit register pointer, MSB first, with the output enable high for all 64 bits.
- R7: A write drives the turnaround as 1,0 and then the low half of the data register as it was when the command was accepted. The output enable is high for all 64 bits. Writing the data register updates only its low half.
- R8: For both read opcodes (bit 1 of the opcode set), the output enable is low from the first turnaround bit through the last data bit. MDIO is sampled on the 16 MDC rising edges of the data field, MSB first, and the result is placed in bits 31:16 of the data word. Bits 15:0 are unchanged. The upper half changes only at the end of a read frame.
- R9: MDIO and its output enable do not change while MDC is high.
- R10: A command written while go reads 1 is ignored: the fields are unchanged and no extra frame follows.
- R11: A command written with go = 0 while idle stores the fields without starting a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command word readback, go in bit 30 |
| data_we | input | 1 | Write strobe for the data low half |
| data_wdata | input | 16 | Write data for the next write frame |
| data_rdata | output | 32 | Read data in 31:16, write data in 15:0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data from the line |

## Verification
A table of transactions covers every opcode, including the increment-read code that shares the read turnaround. It mixes field values of all zeros, all ones and alternating bits with asymmetric read patterns such as 0x0001 and 0x8000. These values catch swapped port and device fields, bit-order reversal, and an off-by-one in where sampling starts. A passive PHY model records each bit and its enable on the MDC rising edge and drives read data between edges. Each captured frame is compared, field by field, against one built independently in the bench. Directed cases then cover the reset state, a second command arriving mid-frame, a command written with go clear, and a data write that must leave the read half untouched.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RDINC = 2'b10,
    OP_READ  = 2'b11
  } mdio_op_e;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int CMD_GO_BIT = 30;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] regad;
  } mdio_cmd_t;

  function automatic logic op_is_read(input logic [1:0] op);
    return op[1];
  endfunction

  // Frame image, first transmitted bit in bit 63.
  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                         input logic [15:0] wdata);
    logic [15:0] payload;
    logic [1:0]  ta;
    payload = (c.op == OP_ADDR) ? c.regad : wdata;
    ta      = op_is_read(c.op) ? 2'b11 : 2'b10;
    return {{PRE_BITS{1'b1}}, 2'b00, c.op, c.port, c.dev, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_c45_mdc_gen.sv
module mdio_c45_mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_now,
  output logic bit_last
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PW   = $clog2(CLK_DIV);

  logic [PW-1:0] ph;
  logic          mdc_q;

  assign rise_now = run && (ph == PW'(HALF - 1));
  assign bit_last = run && (ph == PW'(CLK_DIV - 1));
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      ph    <= '0;
      mdc_q <= 1'b0;
    end else begin
      ph <= bit_last ? '0 : ph + 1'b1;
      if (rise_now)      mdc_q <= 1'b1;
      else if (bit_last) mdc_q <= 1'b0;
    end
  end

  // R3: a bit never ends while MDC is still low from its first half
  p_high_at_bit_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_last |-> mdc_q);

endmodule

// File: rtl/mdio_c45_frame_eng.sv
module mdio_c45_frame_eng
  import mdio_c45_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_rd,
  input  logic                  rise_now,
  input  logic                  bit_last,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done_rd,
  output logic [15:0]           rx_data
);
  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  rd_q;
  logic                  last_bit;

  assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
  assign done_rd  = busy && bit_last && last_bit && rd_q;
  assign mdio_o   = busy && sh[FRAME_BITS-1];
  assign mdio_oe  = busy && !(rd_q && idx >= IDX_W'(TA_FIRST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      rx_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        sh   <= frame;
        idx  <= '0;
        rd_q <= is_rd;
      end
    end else begin
      if (rise_now && rd_q && idx >= IDX_W'(DATA_FIRST))
        rx_data <= {rx_data[14:0], mdio_i};
      if (bit_last) begin
        sh <= {sh[FRAME_BITS-2:0], 1'b0};
        if (last_bit) busy <= 1'b0;
        else          idx  <= idx + 1'b1;
      end
    end
  end

  // R8: the line is never driven in the data field of a read
  p_read_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && rise_now && idx >= IDX_W'(DATA_FIRST)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_c45_host_regs.sv
module mdio_c45_host_regs
  import mdio_c45_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        data_we,
  input  logic [15:0] data_wdata,
  input  logic        busy,
  input  logic        done_rd,
  input  logic [15:0] rx_data,
  output mdio_cmd_t   cmd_q,
  output logic        start,
  output logic [15:0] data_lo,
  output logic [15:0] data_hi
);
  logic cmd_accept;
  logic unused_rsvd;

  assign unused_rsvd = ^{cmd_wdata[31], cmd_wdata[29:28]};
  assign cmd_accept  = cmd_we && !busy;
  assign start       = cmd_accept && cmd_wdata[CMD_GO_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      data_lo <= '0;
      data_hi <= '0;
    end else begin
      if (cmd_accept) cmd_q   <= mdio_cmd_t'(cmd_wdata[27:0]);
      if (data_we)    data_lo <= data_wdata;
      if (done_rd)    data_hi <= rx_data;
    end
  end

  // R10: a command during a frame leaves the stored fields alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_we) |=> $stable(cmd_q));

  // R11: a command with go clear never starts a frame
  p_no_go_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && !cmd_wdata[CMD_GO_BIT]) |=> !busy);

  // R8: read half changes only at the end of a read frame
  p_rdata_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_hi) |-> $past(done_rd));

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic        data_we,
  input  logic [15:0] data_wdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_CLKS = FRAME_BITS * CLK_DIV;

  logic                  busy, start, done_rd, rise_now, bit_last, is_rd;
  logic [15:0]           rx_data, data_lo, data_hi;
  logic [FRAME_BITS-1:0] frame;
  mdio_cmd_t             cmd_q, new_cmd;

  assign new_cmd = mdio_cmd_t'(cmd_wdata[27:0]);
  assign frame   = build_frame(new_cmd, data_lo);
  assign is_rd   = op_is_read(new_cmd.op);

  mdio_c45_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .busy(busy),
    .done_rd(done_rd), .rx_data(rx_data), .cmd_q(cmd_q), .start(start),
    .data_lo(data_lo), .data_hi(data_hi)
  );

  mdio_c45_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
    .rise_now(rise_now), .bit_last(bit_last)
  );

  mdio_c45_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .is_rd(is_rd),
    .rise_now(rise_now), .bit_last(bit_last), .mdio_i(mdio_i), .busy(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done_rd(done_rd), .rx_data(rx_data)
  );

  assign cmd_rdata  = {1'b0, busy, 2'b00, cmd_q};
  assign data_rdata = {data_hi, data_lo};

  // Checker: clocks spent busy in the current frame
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R2: go stays set for exactly one frame length
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == FRAME_CLKS));

  // R3: MDC is quiet outside a frame
  p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R9: line held steady through the high phase of MDC
  p_mdio_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/mdio_c45_master_tb.sv
module mdio_c45_master_tb;
  localparam int DIV = 4;
  localparam int FCLKS = 64 * DIV;
  localparam int NV = 7;
  // {op, port, dev, regad, wdata, phy read value}
  localparam logic [59:0] VEC [NV] = '{
    {2'b00, 5'd3,  5'd1,  16'h0000, 16'h0000, 16'h0000},
    {2'b01, 5'd3,  5'd1,  16'h1234, 16'hA5C3, 16'h0000},
    {2'b11, 5'd3,  5'd1,  16'h0000, 16'h0F0F, 16'h0001},
    {2'b00, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 16'h0000},
    {2'b11, 5'd21, 5'd10, 16'h0000, 16'h5555, 16'h8000},
    {2'b10, 5'd10, 5'd21, 16'h0000, 16'h00FF, 16'hC3A5},
    {2'b01, 5'd0,  5'd0,  16'h0000, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, data_we = 1'b0, mdio_i = 1'b1;
  logic [31:0] cmd_wdata = '0;
  logic [15:0] data_wdata = '0;
  logic [31:0] cmd_rdata, data_rdata;
  logic mdc, mdio_o, mdio_oe;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int cap_idx = 0, gap_bad = 0, last_rise = 0, busy_clks = 0;
  logic [63:0] cap_bits, cap_oe;
  logic [15:0] phy_val = '0;
  logic mdc_prev = 1'b0;
  logic [15:0] exp_hi = '0;

  always #2.5 clk = ~clk;

  mdio_c45_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // Passive PHY: record on MDC rise, present read bits between rises
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && !mdc_prev) begin
      if (cap_idx < 64) begin
        cap_bits[63-cap_idx] = mdio_o;
        cap_oe[63-cap_idx]   = mdio_oe;
      end
      if (cap_idx > 0 && (cyc - last_rise) != DIV) gap_bad = gap_bad + 1;
      last_rise = cyc;
      cap_idx = cap_idx + 1;
    end
    mdc_prev = mdc;
    if (cmd_rdata[30]) busy_clks = busy_clks + 1;
    mdio_i = (cap_idx >= 48 && cap_idx < 64) ? phy_val[63-cap_idx] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    cap_idx = 0; gap_bad = 0; busy_clks = 0; cap_bits = '0; cap_oe = '0;
  endtask

  task automatic write_cmd(input logic go, input logic [1:0] op, input logic [4:0] port,
                           input logic [4:0] dev, input logic [15:0] ra);
    @(negedge clk);
    cmd_wdata = {1'b0, go, 2'b00, op, port, dev, ra};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (cmd_rdata[30] && guard < 4 * FCLKS) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 4 * FCLKS, "R2 go clears", 64'(guard), 64'(FCLKS));
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input logic [1:0] op, input logic [4:0] port,
                             input logic [4:0] dev, input logic [15:0] ra,
                             input logic [15:0] wd);
    logic [63:0] exp_oe;
    logic rd;
    rd = op[1];
    exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    chk(cap_idx == 64, "R3 rising edge count", 64'(cap_idx), 64'd64);
    chk(gap_bad == 0, "R3 MDC period", 64'(gap_bad), 64'd0);
    chk(busy_clks == FCLKS, "R2 go duration", 64'(busy_clks), 64'(FCLKS));
    chk(cap_bits[63:30] == {32'hFFFFFFFF, 2'b00}, "R4 preamble and start",
        64'(cap_bits[63:30]), 64'({32'hFFFFFFFF, 2'b00}));
    chk(cap_bits[29:18] == {op, port, dev}, "R5 op/port/dev",
        64'(cap_bits[29:18]), 64'({op, port, dev}));
    chk(cap_oe == exp_oe, rd ? "R8 release pattern" : "R6 enable pattern",
        cap_oe, exp_oe);
    if (op == 2'b00)
      chk(cap_bits[17:0] == {2'b10, ra}, "R6 address payload",
          64'(cap_bits[17:0]), 64'({2'b10, ra}));
    else if (op == 2'b01)
      chk(cap_bits[17:0] == {2'b10, wd}, "R7 write payload",
          64'(cap_bits[17:0]), 64'({2'b10, wd}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_rdata == 32'h0 && data_rdata == 32'h0, "R1 registers after reset",
        {cmd_rdata, data_rdata}, 64'h0);
    chk(!mdc && !mdio_oe, "R1 pins after reset", {62'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [4:0] port, dev; logic [15:0] ra, wd, pv;
      {op, port, dev, ra, wd, pv} = VEC[i];
      @(negedge clk);
      data_wdata = wd; data_we = 1'b1;
      @(negedge clk);
      data_we = 1'b0;
      phy_val = pv;
      mon_clear();
      write_cmd(1'b1, op, port, dev, ra);
      wait_idle();
      check_frame(op, port, dev, ra, wd);
      chk(cmd_rdata == {4'b0000, op, port, dev, ra}, "R2 fields read back",
          64'(cmd_rdata), 64'({4'b0000, op, port, dev, ra}));
      if (op[1]) exp_hi = pv;
      chk(data_rdata == {exp_hi, wd}, "R8 data word after frame",
          64'(data_rdata), 64'({exp_hi, wd}));
    end

    // R10: second command mid-frame is dropped
    mon_clear();
    write_cmd(1'b1, 2'b00, 5'd7, 5'd3, 16'hBEEF);
    repeat (50) @(negedge clk);
    write_cmd(1'b1, 2'b11, 5'd30, 5'd29, 16'h1111);
    wait_idle();
    check_frame(2'b00, 5'd7, 5'd3, 16'hBEEF, 16'h0);
    chk(cmd_rdata == {4'b0000, 2'b00, 5'd7, 5'd3, 16'hBEEF}, "R10 fields kept",
        64'(cmd_rdata), 64'({4'b0000, 2'b00, 5'd7, 5'd3, 16'hBEEF}));
    repeat (2 * FCLKS) @(negedge clk);
    chk(cap_idx == 64 && !cmd_rdata[30], "R10 no extra frame", 64'(cap_idx), 64'd64);

    // R11: go clear stores fields, no frame
    mon_clear();
    write_cmd(1'b0, 2'b01, 5'd12, 5'd5, 16'h4242);
    repeat (100) @(negedge clk);
    chk(cap_idx == 0 && !mdc, "R11 no activity", 64'(cap_idx), 64'd0);
    chk(cmd_rdata == {4'b0000, 2'b01, 5'd12, 5'd5, 16'h4242}, "R11 fields stored",
        64'(cmd_rdata), 64'({4'b0000, 2'b01, 5'd12, 5'd5, 16'h4242}));

    // R7: data write touches only the low half
    @(negedge clk);
    data_wdata = 16'h9876; data_we = 1'b1;
    @(negedge clk);
    data_we = 1'b0;
    @(negedge clk);
    chk(data_rdata == {exp_hi, 16'h9876}, "R7 low half only",
        64'(data_rdata), 64'({exp_hi, 16'h9876}));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule